// File: doc/BRIEF.md
# Paged GPIO Bus Register Interface

This block is the byte-wide register front end of a 48-line open-drain digital I/O controller. A host reaches it over an 8-bit address bus and an 8-bit data bus with separate read and write strobes. Six port registers set which lines sink current. One control register holds a lock bit for each port and a two-bit page field. The page field chooses what the three-register window just above the control register reaches. A port bit at 1 pulls its line low. A port bit at 0 releases the line, so it can serve as an input. Port reads return the inverted, synchronized pin level.

The interrupt capture bank sits outside this block. It holds the edge polarity, enable and interrupt ID registers. The block reaches it through a side interface that carries the page, the register index within the window, a write pulse, a read pulse and the data in both directions. The bank also supplies a pending summary byte, which the host reads at a fixed offset.

Read data is registered. It appears on `rdata_o` one clock after the read strobe and holds until the next read.

Top module: `gpio_paged_regif`

## Requirements
- R1: After reset, every port register is 0 and `pin_sink_o` is all zeros. The page is 0, all locks are clear, and `rdata_o` is 0x00.
- R2: A write to offset p (0 to 5) to an unlocked port sets `pin_sink_o[8p+n]` to data bit n. The change is visible the clock after the strobe.
- R3: A read of offset p (0 to 5) returns bit n = 1 when line 8p+n is low. It returns 0 when the line is high. Pin levels pass through two synchronizing flops, so a read issued in the cycle the level changes still returns the old level.
- R4: Offset 0x6 reads the pending summary byte `pend_i`. A write to 0x6 changes no port, lock or page state and produces no bank write.
- R5: Bits 0 to 5 of offset 0x7 lock ports 0 to 5. A write to a locked port is dropped. Lock bits can be rewritten at any time, and a read of 0x7 returns the locks in bits 0 to 5 and the page in bits 7:6.
- R6: The page value sets the window's target. Page 1 selects the polarity registers, page 2 the enable registers and page 3 the interrupt ID registers. A window access drives `bank_page_o` with the page and `bank_idx_o` with the offset minus 0x8. A write pulses `bank_wr_o` with `bank_wdata_o`, and a read returns `bank_rdata_i`.
- R7: On page 0, window reads return 0x00 and window writes produce no bank write. Offsets above 0xA read 0x00, and writes to them have no effect.
- R8: When read and write strobes arrive in the same cycle at one offset, the read returns the value held before the write, and the write still takes effect.
- R9: `rdata_o` changes only on a read strobe. Idle cycles and writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pin_in_i | input | 48 | Pin levels (asynchronous) |
| pin_sink_o | output | 48 | 1 = sink current on that line |
| pend_i | input | 8 | Pending summary from the interrupt bank |
| bank_page_o | output | 2 | Page selected for the window (1 polarity, 2 enable, 3 ID) |
| bank_idx_o | output | 2 | Register index within the window |
| bank_wr_o | output | 1 | Window write pulse to the bank |
| bank_rd_o | output | 1 | Window read pulse to the bank |
| bank_wdata_o | output | 8 | Write data to the bank |
| bank_rdata_i | input | 8 | Read data from the bank |

## Verification
A read and a write can fall in the same cycle at one offset. The bench provokes this by raising both strobes together, once on a port register and once on the page and lock register. It judges the result two ways: the returned byte must be the value held before the write, and a later read or the pin outputs must show that the write took hold. The bench also drives a pin level change in the same cycle as a port read. That read must still return the level from before the change, which shows the synchronizer delay.

// File: rtl/gpio_regif_pkg.sv
package gpio_regif_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned PAGE_LSB = 6;

  typedef enum logic [1:0] {
    PG_NONE  = 2'd0,
    PG_POL   = 2'd1,
    PG_ENAB  = 2'd2,
    PG_IRQID = 2'd3
  } page_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 48,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (STAGES == 0) begin : g_bypass
    assign q_o = d_i;
  end else begin : g_chain
    logic [STAGES-1:0][WIDTH-1:0] stg_q;
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     stg_q[s] <= '1;  // released lines idle high
        else if (s == 0) stg_q[s] <= d_i;
        else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
      end
    end
    assign q_o = stg_q[STAGES-1];
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_regif_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  localparam int unsigned IDX_W    = $clog2(NUM_PORTS),
  localparam int unsigned LINES    = NUM_PORTS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_PORTS-1:0] lock_i,
  output logic [LINES-1:0]  sink_o
);
  logic [NUM_PORTS-1:0][DATA_W-1:0] port_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic wr_hit;
    assign wr_hit = wr_i && (sel_i == IDX_W'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   port_q[p] <= '0;
      else if (wr_hit && !lock_i[p]) port_q[p] <= wdata_i;
    end

    a_r5_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_i[p] |=> port_q[p] == $past(port_q[p]));

    a_r2_port_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_hit && !lock_i[p]) |=> port_q[p] == $past(wdata_i));
  end

  assign sink_o = port_q;
endmodule

// File: rtl/gpio_page_lock.sv
module gpio_page_lock
  import gpio_regif_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [NUM_PORTS-1:0] lock_o,
  output page_e                page_o,
  output logic [DATA_W-1:0]    value_o
);
  logic [NUM_PORTS-1:0] lock_q;
  page_e                page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      page_q <= PG_NONE;
    end else if (wr_i) begin
      lock_q <= wdata_i[NUM_PORTS-1:0];
      page_q <= page_e'(wdata_i[DATA_W-1:PAGE_LSB]);
    end
  end

  always_comb begin
    value_o = '0;
    value_o[NUM_PORTS-1:0]        = lock_q;
    value_o[DATA_W-1:PAGE_LSB]    = page_q;
  end

  assign lock_o = lock_q;
  assign page_o = page_q;
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regif_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 6,
  parameter int unsigned WIN_REGS  = 3,
  localparam int unsigned IDX_W     = $clog2(NUM_PORTS),
  localparam int unsigned WIN_IDX_W = $clog2(WIN_REGS),
  localparam int unsigned PEND_ADDR = NUM_PORTS,
  localparam int unsigned CTRL_ADDR = NUM_PORTS + 1,
  localparam int unsigned WIN_BASE  = NUM_PORTS + 2,
  localparam int unsigned WIN_LAST  = WIN_BASE + WIN_REGS - 1
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  page_e                page_i,
  output logic                 port_hit_o,
  output logic [IDX_W-1:0]     port_idx_o,
  output logic                 pend_hit_o,
  output logic                 ctrl_hit_o,
  output logic                 win_hit_o,
  output logic [WIN_IDX_W-1:0] win_idx_o
);
  logic in_win;

  assign port_hit_o = addr_i < ADDR_W'(NUM_PORTS);
  assign port_idx_o = port_hit_o ? IDX_W'(addr_i) : '0;
  assign pend_hit_o = addr_i == ADDR_W'(PEND_ADDR);
  assign ctrl_hit_o = addr_i == ADDR_W'(CTRL_ADDR);
  assign in_win     = (addr_i >= ADDR_W'(WIN_BASE)) && (addr_i <= ADDR_W'(WIN_LAST));
  assign win_hit_o  = in_win && (page_i != PG_NONE);
  assign win_idx_o  = win_hit_o ? WIN_IDX_W'(addr_i - ADDR_W'(WIN_BASE)) : '0;
endmodule

// File: rtl/gpio_paged_regif.sv
module gpio_paged_regif
  import gpio_regif_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 6,
  parameter int unsigned WIN_REGS    = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned LINES      = NUM_PORTS * DATA_W,
  localparam int unsigned WIN_IDX_W  = $clog2(WIN_REGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [LINES-1:0]     pin_in_i,
  output logic [LINES-1:0]     pin_sink_o,
  input  logic [DATA_W-1:0]    pend_i,
  output logic [1:0]           bank_page_o,
  output logic [WIN_IDX_W-1:0] bank_idx_o,
  output logic                 bank_wr_o,
  output logic                 bank_rd_o,
  output logic [DATA_W-1:0]    bank_wdata_o,
  input  logic [DATA_W-1:0]    bank_rdata_i
);
  localparam int unsigned IDX_W = $clog2(NUM_PORTS);

  logic                 port_hit, pend_hit, ctrl_hit, win_hit;
  logic [IDX_W-1:0]     port_idx;
  logic [WIN_IDX_W-1:0] win_idx;
  logic [NUM_PORTS-1:0] lock;
  page_e                page;
  logic [DATA_W-1:0]    ctrl_val;
  logic [LINES-1:0]     pin_sync;
  logic [NUM_PORTS-1:0][DATA_W-1:0] pin_bytes;
  logic [DATA_W-1:0]    rd_val;
  logic [DATA_W-1:0]    rdata_q;

  gpio_addr_decode #(.NUM_PORTS(NUM_PORTS), .WIN_REGS(WIN_REGS)) u_dec (
    .addr_i     (addr_i),
    .page_i     (page),
    .port_hit_o (port_hit),
    .port_idx_o (port_idx),
    .pend_hit_o (pend_hit),
    .ctrl_hit_o (ctrl_hit),
    .win_hit_o  (win_hit),
    .win_idx_o  (win_idx)
  );

  gpio_page_lock #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i && ctrl_hit),
    .wdata_i (wdata_i),
    .lock_o  (lock),
    .page_o  (page),
    .value_o (ctrl_val)
  );

  gpio_port_bank #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i && port_hit),
    .sel_i   (port_idx),
    .wdata_i (wdata_i),
    .lock_i  (lock),
    .sink_o  (pin_sink_o)
  );

  gpio_in_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (pin_sync)
  );

  assign pin_bytes    = pin_sync;
  assign bank_page_o  = page;
  assign bank_idx_o   = win_idx;
  assign bank_wr_o    = wr_i && win_hit;
  assign bank_rd_o    = rd_i && win_hit;
  assign bank_wdata_o = wdata_i;

  always_comb begin
    rd_val = '0;
    if (port_hit)      rd_val = ~pin_bytes[port_idx];  // 1 = line low
    else if (pend_hit) rd_val = pend_i;
    else if (ctrl_hit) rd_val = ctrl_val;
    else if (win_hit)  rd_val = bank_rdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  a_r7_page0_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (page == PG_NONE) |-> !bank_wr_o && !bank_rd_o);

  a_r4_pend_no_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && pend_hit) |-> !bank_wr_o);

  a_r8_ctrl_read_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i && ctrl_hit) |=> rdata_o == $past(ctrl_val));

  a_r9_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  a_r6_bank_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bank_wr_o && !wr_i, bank_rd_o && !rd_i}) && !(bank_wr_o && !wr_i));
endmodule

// File: tb/gpio_paged_regif_test.sv
`timescale 1ns/1ps
module gpio_paged_regif_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata;
  logic [47:0] pin_in, pin_sink;
  logic [47:0] ext_low = '0;
  logic [7:0]  pend = 8'h81;
  logic [1:0]  bpage, bidx;
  logic        bwr, brd;
  logic [7:0]  bwdata, brdata;
  logic [7:0]  bank_mem [4][4];

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic cap_wr; logic [1:0] cap_idx, cap_page;

  always #2.5 clk = ~clk;

  assign pin_in = ~(pin_sink | ext_low);   // open-drain line model
  assign brdata = bank_mem[bpage][bidx];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) for (int j = 0; j < 4; j++) bank_mem[i][j] <= '0;
    end else if (bwr) bank_mem[bpage][bidx] <= bwdata;
  end

  gpio_paged_regif uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .pin_in_i(pin_in), .pin_sink_o(pin_sink), .pend_i(pend),
    .bank_page_o(bpage), .bank_idx_o(bidx), .bank_wr_o(bwr), .bank_rd_o(brd),
    .bank_wdata_o(bwdata), .bank_rdata_i(brdata)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // strobe for one edge; captures the side-interface outputs mid-cycle
  task automatic op(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = w; rd = r;
    #1;
    cap_wr = bwr; cap_idx = bidx; cap_page = bpage;
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // {op(1=read), req, addr, data, exp}
  localparam int NV = 24;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 4'd2, 8'h00, 8'hA5, 8'h00},  // R2 write port0
    {1'b1, 4'd3, 8'h00, 8'h00, 8'hA5},  // R3 readback inverted
    {1'b0, 4'd2, 8'h05, 8'h3C, 8'h00},  // R2 port5
    {1'b1, 4'd3, 8'h05, 8'h00, 8'h3C},  // R3
    {1'b0, 4'd5, 8'h07, 8'h01, 8'h00},  // R5 lock port0
    {1'b0, 4'd5, 8'h00, 8'hFF, 8'h00},  // R5 dropped
    {1'b1, 4'd5, 8'h00, 8'h00, 8'hA5},  // R5 unchanged
    {1'b1, 4'd5, 8'h07, 8'h00, 8'h01},  // R5 readback
    {1'b0, 4'd5, 8'h07, 8'h00, 8'h00},  // R5 unlock
    {1'b0, 4'd5, 8'h00, 8'h0F, 8'h00},  // R5 write accepted
    {1'b1, 4'd5, 8'h00, 8'h00, 8'h0F},  // R5
    {1'b0, 4'd4, 8'h06, 8'h55, 8'h00},  // R4 write ignored
    {1'b1, 4'd4, 8'h06, 8'h00, 8'h81},  // R4 pending
    {1'b1, 4'd7, 8'h0B, 8'h00, 8'h00},  // R7 above window
    {1'b0, 4'd6, 8'h07, 8'h40, 8'h00},  // R6 page1
    {1'b0, 4'd6, 8'h08, 8'h11, 8'h00},  // R6 polarity0
    {1'b1, 4'd6, 8'h08, 8'h00, 8'h11},  // R6
    {1'b0, 4'd6, 8'h07, 8'h80, 8'h00},  // R6 page2
    {1'b0, 4'd6, 8'h09, 8'h22, 8'h00},  // R6 enable1
    {1'b1, 4'd6, 8'h09, 8'h00, 8'h22},  // R6
    {1'b1, 4'd6, 8'h08, 8'h00, 8'h00},  // R6 enable0 untouched
    {1'b0, 4'd7, 8'h07, 8'h00, 8'h00},  // R7 page0
    {1'b1, 4'd7, 8'h08, 8'h00, 8'h00},  // R7 window reads zero
    {1'b0, 4'd7, 8'h08, 8'h77, 8'h00}   // R7 ignored
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sink", pin_sink, 48'h0);
    check("R1 rdata", {40'h0, rdata}, 48'h0);
    check("R1 page", {46'h0, bpage}, 48'h0);
    rst_n = 1'b1;
    settle();
    op(0, 1, 8'h07, 8'h00);
    check("R1 ctrl", {40'h0, rdata}, 48'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) begin
        op(0, 1, VEC[i][23:16], 8'h00);
        check($sformatf("R%0d vec%0d", VEC[i][27:24], i), {40'h0, rdata}, {40'h0, VEC[i][7:0]});
      end else begin
        op(1, 0, VEC[i][23:16], VEC[i][15:8]);
      end
      settle();
    end

    // R7 page0 write left polarity0 alone
    op(1, 0, 8'h07, 8'h40); settle();
    op(0, 1, 8'h08, 8'h00);
    check("R7 pol0 kept", {40'h0, rdata}, 48'h11);
    op(0, 1, 8'h07, 8'h00);
    check("R5 page readback", {40'h0, rdata}, 48'h40);

    // R6 side interface on page 2, index 2
    op(1, 0, 8'h07, 8'h80);
    op(1, 0, 8'h0A, 8'h5A);
    check("R6 bank_wr", {47'h0, cap_wr}, 48'h1);
    check("R6 bank_idx", {46'h0, cap_idx}, 48'h2);
    check("R6 bank_page", {46'h0, cap_page}, 48'h2);

    // R4 pending write produces no bank write and no state change
    op(1, 0, 8'h06, 8'hFF);
    check("R4 bank_wr", {47'h0, cap_wr}, 48'h0);
    check("R4 sink", pin_sink, {8'h3C, 32'h0, 8'h0F});

    // R7 page0 write produces no bank write
    op(1, 0, 8'h07, 8'h00);
    op(1, 0, 8'h09, 8'hEE);
    check("R7 bank_wr", {47'h0, cap_wr}, 48'h0);
    op(1, 0, 8'h0C, 8'hFF);
    check("R7 high addr sink", pin_sink, {8'h3C, 32'h0, 8'h0F});

    // R3 sync latency with external pull-down on port2
    @(negedge clk);
    ext_low[23:16] = 8'h81; addr = 8'h02; rd = 1;
    @(negedge clk); rd = 0;
    check("R3 old level", {40'h0, rdata}, 48'h0);
    settle();
    op(0, 1, 8'h02, 8'h00);
    check("R3 new level", {40'h0, rdata}, 48'h81);

    // R8 simultaneous read and write
    op(1, 0, 8'h01, 8'h0F); settle();
    op(1, 1, 8'h01, 8'hF0);
    check("R8 port old", {40'h0, rdata}, 48'h0F);
    check("R8 port new", pin_sink[15:8], 48'hF0);
    op(1, 0, 8'h07, 8'h40);
    op(1, 1, 8'h07, 8'h80);
    check("R8 ctrl old", {40'h0, rdata}, 48'h40);
    op(0, 1, 8'h07, 8'h00);
    check("R8 ctrl new", {40'h0, rdata}, 48'h80);

    // R9 rdata holds through writes and idle
    op(1, 0, 8'h03, 8'hC3);
    check("R9 after write", {40'h0, rdata}, 48'h80);
    settle();
    check("R9 after idle", {40'h0, rdata}, 48'h80);
    check("R2 port3", pin_sink[31:24], 48'hC3);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule